// File: doc/BRIEF.md
# Clocked Slave Register for an Asynchronous Strobe Bus

This block replaces a level-sensitive register that sat on an old asynchronous peripheral bus with a fully clocked one. Every bus input is treated as asynchronous to the internal clock. These inputs are the active-low write strobe, the write-side port address and select bits, the write data, the two active-low read enables and the read address. The write strobe is resynchronized, and its release (low to high) is detected in the clock domain. On that release the block stores an 8-bit start value, provided the bus fields captured while the strobe was still low name this register.

The read side synchronizes its enables and address through the same kind of two-flop chain. While the read side selects the register, the block presents the stored byte as a 16-bit word with a zero upper byte, together with a read-valid flag. Pad tristating is left to the surrounding logic, which uses the read-valid flag as its output enable.

Top module: `lbr_event_reg`

## Requirements
- R1: A synchronous active-high `rst` clears the stored value to 0x00, and the cleared value is what a selected read returns afterwards.
- R2: A write is accepted when, while `wr_strobe_n` was low, `wr_port_addr` was 0xA5, `wr_sel_data` was 1 and `wr_sel_dir` was 1. The value of `wr_data` is then stored, and it is visible on a selected read by the third rising clock edge after `wr_strobe_n` returns high.
- R3: A strobe pulse whose port address differs from 0xA5 leaves the stored value unchanged.
- R4: A strobe pulse with `wr_sel_data` at 0 leaves the stored value unchanged.
- R5: A strobe pulse with `wr_sel_dir` at 0 leaves the stored value unchanged.
- R6: The fields used for a write are the ones sampled while the strobe was low. Address, select or data changes made together with the strobe release have no effect.
- R7: While the strobe is held low, the stored value does not change. The update happens only after the release.
- R8: A read is selected only when `rd_en_a_n` and `rd_en_b_n` are both 0 and `rd_addr[13:2]` equals 0x033. `rd_addr[1:0]` does not matter.
- R9: During a selected read, `rd_valid` is 1 and `rd_data` equals {8'h00, stored value}. Both appear two rising edges after the read inputs settle.
- R10: When the read is not selected, `rd_valid` is 0 and `rd_data` is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe_n | input | 1 | Asynchronous active-low write strobe |
| wr_port_addr | input | 8 | Write-side port address |
| wr_sel_data | input | 1 | Write qualifier: data-bus select |
| wr_sel_dir | input | 1 | Write qualifier: direction-out select |
| wr_data | input | 8 | Write data byte |
| rd_en_a_n | input | 1 | Active-low read enable, first |
| rd_en_b_n | input | 1 | Active-low read enable, second |
| rd_addr | input | 14 | Read address; bits 13:2 are decoded |
| rd_data | output | 16 | Read word, zero when not selected |
| rd_valid | output | 1 | Read selected, output-enable for the pads |

## Verification
A write becomes visible three rising edges after the strobe release. Two of those edges are synchronizer flops and one is the register load. The bench therefore raises the strobe on a falling edge and inspects the read port four falling edges later. A read-side change appears two rising edges later, so the bench waits two falling edges after moving the read inputs before it samples. While the strobe is still low, the bench samples the read port again to confirm the old value is held. All inputs change, and all outputs are sampled, only on falling edges, so no check depends on the order of processes at the active edge.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    localparam int DATA_W      = 8;
    localparam int WADDR_W     = 8;
    localparam int RADDR_W     = 14;
    localparam int RKEY_LSB    = 2;
    localparam int RKEY_W      = RADDR_W - RKEY_LSB;
    localparam int OUT_W       = 2 * DATA_W;
    localparam int SYNC_DEPTH  = 2;
    localparam int EDGE_DEPTH  = SYNC_DEPTH + 1;

    localparam logic [WADDR_W-1:0] WR_KEY_DEF = 8'hA5;
    localparam logic [RKEY_W-1:0]  RD_KEY_DEF = 12'h033;

    typedef struct packed {
        logic [WADDR_W-1:0] addr;
        logic               sel_data;
        logic               sel_dir;
        logic [DATA_W-1:0]  data;
    } wr_fields_t;

    typedef struct packed {
        logic               en_a_n;
        logic               en_b_n;
        logic [RADDR_W-1:0] addr;
    } rd_fields_t;

    localparam int WR_FIELDS_W = $bits(wr_fields_t);
    localparam int RD_FIELDS_W = $bits(rd_fields_t);

    function automatic logic wr_hit(input wr_fields_t f, input logic [WADDR_W-1:0] key);
        return (f.addr == key) && f.sel_data && f.sel_dir;
    endfunction

    function automatic logic rd_hit(input rd_fields_t f, input logic [RKEY_W-1:0] key);
        return !f.en_a_n && !f.en_b_n && (f.addr[RADDR_W-1:RKEY_LSB] == key);
    endfunction

    function automatic logic [OUT_W-1:0] widen(input logic [DATA_W-1:0] v);
        return {{(OUT_W-DATA_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/lbr_sync_pipe.sv
module lbr_sync_pipe #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_newer,
    output logic [W-1:0] q_older
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= RST_VAL;
        else     st[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) st[g] <= RST_VAL;
                else     st[g] <= st[g-1];
            end
        end
    endgenerate

    assign q_newer = st[STAGES-2];
    assign q_older = st[STAGES-1];
endmodule

// File: rtl/lbr_wr_capture.sv
module lbr_wr_capture
    import lbr_pkg::*;
#(
    parameter logic [WADDR_W-1:0] WR_KEY = WR_KEY_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n,
    input  wr_fields_t        fields,
    output logic              fire,
    output logic [DATA_W-1:0] value
);
    logic       strobe_cur;
    logic       strobe_prev;
    wr_fields_t held_newer;
    wr_fields_t held_older;

    lbr_sync_pipe #(.W(1), .STAGES(EDGE_DEPTH), .RST_VAL(1'b1)) i_strobe_sync (
        .clk(clk), .rst(rst), .d(strobe_n),
        .q_newer(strobe_cur), .q_older(strobe_prev)
    );

    // The fields travel beside the strobe, so the older copy was taken while the strobe was low.
    lbr_sync_pipe #(.W(WR_FIELDS_W), .STAGES(EDGE_DEPTH), .RST_VAL('0)) i_field_pipe (
        .clk(clk), .rst(rst), .d(fields),
        .q_newer(held_newer), .q_older(held_older)
    );

    logic released;
    assign released = strobe_cur && !strobe_prev;
    assign fire     = released && wr_hit(held_older, WR_KEY);
    assign value    = held_older.data;

    // R2: a fire needs a high strobe two edges back and a low one three edges back
    a_r2_fire_after_release: assert property (@(posedge clk) disable iff (rst)
        fire |-> ($past(strobe_n, 2) && !$past(strobe_n, 3)));

    // R3: the address seen with the low strobe must be the key
    a_r3_fire_needs_key: assert property (@(posedge clk) disable iff (rst)
        fire |-> ($past(fields.addr, 3) == WR_KEY));

    // R6: the stored byte is the one present while the strobe was low
    a_r6_value_from_low_phase: assert property (@(posedge clk) disable iff (rst)
        fire |-> (value == $past(fields.data, 3)));

    logic unused_newer;
    assign unused_newer = ^held_newer;
endmodule

// File: rtl/lbr_store.sv
module lbr_store
    import lbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst)       val_q <= '0;
        else if (load) val_q <= din;
    end

    assign q = val_q;

    // R7: the value changes only in the cycle after a detected release
    a_r7_change_needs_fire: assert property (@(posedge clk) disable iff (rst)
        !$stable(val_q) |-> $past(load));

    // R1: directly after reset the value is zero
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (val_q == '0));
endmodule

// File: rtl/lbr_rd_port.sv
module lbr_rd_port
    import lbr_pkg::*;
#(
    parameter logic [RKEY_W-1:0] RD_KEY = RD_KEY_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_fields_t        fields,
    input  logic [DATA_W-1:0] stored,
    output logic [OUT_W-1:0]  data,
    output logic              valid
);
    localparam rd_fields_t IDLE = '{en_a_n: 1'b1, en_b_n: 1'b1, addr: '0};

    rd_fields_t f_newer;
    rd_fields_t f_sync;

    lbr_sync_pipe #(.W(RD_FIELDS_W), .STAGES(SYNC_DEPTH), .RST_VAL(IDLE)) i_rd_sync (
        .clk(clk), .rst(rst), .d(fields),
        .q_newer(f_newer), .q_older(f_sync)
    );

    always_comb begin
        valid = rd_hit(f_sync, RD_KEY);
        data  = valid ? widen(stored) : '0;
    end

    // R8: selection comes from both enables low two edges back
    a_r8_valid_needs_enables: assert property (@(posedge clk) disable iff (rst)
        valid |-> (!$past(fields.en_a_n, 2) && !$past(fields.en_b_n, 2)));

    // R8: and from the decoded address two edges back
    a_r8_valid_needs_addr: assert property (@(posedge clk) disable iff (rst)
        valid |-> ($past(fields.addr[RADDR_W-1:RKEY_LSB], 2) == RD_KEY));

    logic unused_newer;
    assign unused_newer = ^f_newer;
endmodule

// File: rtl/lbr_event_reg.sv
module lbr_event_reg
    import lbr_pkg::*;
#(
    parameter logic [WADDR_W-1:0] WR_KEY = WR_KEY_DEF,
    parameter logic [RKEY_W-1:0]  RD_KEY = RD_KEY_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_strobe_n,
    input  logic [WADDR_W-1:0] wr_port_addr,
    input  logic               wr_sel_data,
    input  logic               wr_sel_dir,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en_a_n,
    input  logic               rd_en_b_n,
    input  logic [RADDR_W-1:0] rd_addr,
    output logic [OUT_W-1:0]   rd_data,
    output logic               rd_valid
);
    wr_fields_t        wf;
    rd_fields_t        rf;
    logic              wr_fire;
    logic [DATA_W-1:0] wr_value;
    logic [DATA_W-1:0] stored;

    assign wf = '{addr: wr_port_addr, sel_data: wr_sel_data, sel_dir: wr_sel_dir, data: wr_data};
    assign rf = '{en_a_n: rd_en_a_n, en_b_n: rd_en_b_n, addr: rd_addr};

    lbr_wr_capture #(.WR_KEY(WR_KEY)) i_wr (
        .clk(clk), .rst(rst), .strobe_n(wr_strobe_n), .fields(wf),
        .fire(wr_fire), .value(wr_value)
    );

    lbr_store i_store (
        .clk(clk), .rst(rst), .load(wr_fire), .din(wr_value), .q(stored)
    );

    lbr_rd_port #(.RD_KEY(RD_KEY)) i_rd (
        .clk(clk), .rst(rst), .fields(rf), .stored(stored),
        .data(rd_data), .valid(rd_valid)
    );

    // R10: an unselected read never shows data
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (rd_en_a_n && $past(rd_en_a_n) && $past(rd_en_a_n, 2)) |-> (!rd_valid && rd_data == '0));
endmodule

// File: tb/test_lbr_event_reg.sv
module test_lbr_event_reg;
    logic        clk = 0;
    logic        rst;
    logic        wr_strobe_n;
    logic [7:0]  wr_port_addr;
    logic        wr_sel_data;
    logic        wr_sel_dir;
    logic [7:0]  wr_data;
    logic        rd_en_a_n;
    logic        rd_en_b_n;
    logic [13:0] rd_addr;
    logic [15:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    lbr_event_reg i_lbr_event_reg (
        .clk(clk), .rst(rst), .wr_strobe_n(wr_strobe_n), .wr_port_addr(wr_port_addr),
        .wr_sel_data(wr_sel_data), .wr_sel_dir(wr_sel_dir), .wr_data(wr_data),
        .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    localparam logic [13:0] RD_SEL = {12'h033, 2'b00};

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sel_read(input logic a_n, input logic b_n, input logic [13:0] addr);
        rd_en_a_n = a_n; rd_en_b_n = b_n; rd_addr = addr;
        waitn(2);
    endtask

    // strobe pulse; optional change of all fields together with the release
    task automatic pulse(input logic [7:0] addr, input logic sd, input logic sr,
                         input logic [7:0] d, input logic late, input logic [7:0] hold_exp);
        wr_port_addr = addr; wr_sel_data = sd; wr_sel_dir = sr; wr_data = d;
        wr_strobe_n = 0;
        waitn(4);
        check("R7 held while strobe low", {rd_valid, rd_data}, {1'b1, 8'h00, hold_exp});
        wr_strobe_n = 1;
        if (late) begin
            wr_data = ~d; wr_port_addr = 8'h00; wr_sel_data = 0; wr_sel_dir = 0;
        end
        waitn(4);
    endtask

    task automatic t_reset;
        rst = 1; wr_strobe_n = 1; wr_port_addr = 0; wr_sel_data = 0; wr_sel_dir = 0;
        wr_data = 0; rd_en_a_n = 1; rd_en_b_n = 1; rd_addr = 0;
        waitn(3);
        rst = 0;
        waitn(2);
        check("R10 idle after reset", {rd_valid, rd_data}, 17'h0);
        sel_read(0, 0, RD_SEL);
        check("R1 reset value", {rd_valid, rd_data}, {1'b1, 16'h0000});
    endtask

    task automatic t_write;
        pulse(8'hA5, 1, 1, 8'h3C, 0, 8'h00);
        check("R2 qualified write", {rd_valid, rd_data}, {1'b1, 16'h003C});
        pulse(8'hA5, 1, 1, 8'hC3, 0, 8'h3C);
        check("R9 zero upper byte", {rd_valid, rd_data}, {1'b1, 16'h00C3});
    endtask

    task automatic t_ignored;
        pulse(8'hA4, 1, 1, 8'h11, 0, 8'hC3);
        check("R3 address mismatch", {rd_valid, rd_data}, {1'b1, 16'h00C3});
        pulse(8'hA5, 0, 1, 8'h22, 0, 8'hC3);
        check("R4 data select low", {rd_valid, rd_data}, {1'b1, 16'h00C3});
        pulse(8'hA5, 1, 0, 8'h33, 0, 8'hC3);
        check("R5 direction select low", {rd_valid, rd_data}, {1'b1, 16'h00C3});
    endtask

    task automatic t_late;
        pulse(8'hA5, 1, 1, 8'h5A, 1, 8'hC3);
        check("R6 late change ignored", {rd_valid, rd_data}, {1'b1, 16'h005A});
    endtask

    task automatic t_read_decode;
        sel_read(0, 0, RD_SEL | 14'h3);
        check("R8 low address bits ignored", {rd_valid, rd_data}, {1'b1, 16'h005A});
        sel_read(0, 0, RD_SEL ^ 14'h4);
        check("R10 address bit 2 off", {rd_valid, rd_data}, 17'h0);
        sel_read(1, 0, RD_SEL);
        check("R8 first enable high", {rd_valid, rd_data}, 17'h0);
        sel_read(0, 1, RD_SEL);
        check("R8 second enable high", {rd_valid, rd_data}, 17'h0);
        sel_read(0, 0, 14'h3FFC);
        check("R10 wrong address", {rd_valid, rd_data}, 17'h0);
        rd_en_a_n = 0; rd_en_b_n = 0; rd_addr = RD_SEL;
        waitn(1);
        check("R9 not valid after one edge", {16'h0, rd_valid}, 17'h0);
        waitn(1);
        check("R9 valid after two edges", {rd_valid, rd_data}, {1'b1, 16'h005A});
    endtask

    task automatic t_reset_again;
        rst = 1;
        waitn(2);
        rst = 0;
        waitn(2);
        check("R1 reset clears stored value", {rd_valid, rd_data}, {1'b1, 16'h0000});
    endtask

    initial begin
        t_reset();
        t_write();
        t_ignored();
        t_late();
        t_read_decode();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule